// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a compact in-order processor core with five pipeline stages: fetch, decode, execute, memory and write-back. It runs a 32-bit load/store integer subset: register-register add, subtract, AND, OR and signed set-less-than; add-immediate and AND-immediate; word load and word store; and branch-if-equal and branch-if-not-equal. The instruction memory, the data memory and the 32-entry register file are internal word arrays.

Program and data are placed through a load port, normally while the core is held in reset. Results are read back through a combinational peek port. Data dependencies between ALU instructions are served by operand forwarding into the execute stage. A hazard unit inserts bubbles where forwarding cannot help: a consumer that directly follows a load, and a branch whose operands are still in flight. Branches are compared in decode. Fetch always continues sequentially, and a taken branch discards the one instruction fetched behind it.

The external reset is asynchronous and active-low. It is released into the pipeline through a two-flop synchronizer, so fetch begins two clock edges after `rst_n` rises.

Top module: `core_pipe5`

## Requirements
- R1: While reset is asserted, the program counter reads 0 and no pipeline stage holds an instruction. The counter stays 0 until the synchronizer releases the pipeline.
- R2: Opcode field [31:26] selects the instruction: 000000 register-register, 001000 add-immediate, 001100 AND-immediate, 100011 load, 101011 store, 000100 branch-equal, 000101 branch-not-equal. For register-register instructions, function field [5:0] selects the operation: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 set-less-than. Any other opcode or function code behaves as a no-operation and writes nothing.
- R3: Add-immediate, load and store sign-extend the 16-bit immediate [15:0]. AND-immediate zero-extends it. Immediate forms write register rt [20:16]. Register-register forms write rd [15:11] and read rs [25:21] and rt [20:16].
- R4: Set-less-than compares its operands as signed two's-complement numbers and writes 1 or 0.
- R5: An ALU operand is forwarded from the execute/memory register or from the memory/write-back register without a stall. When both stages hold the same destination, the younger result (execute/memory) wins.
- R6: Register 0 always reads zero. Writes to it are discarded, and it is never used as a forwarding source.
- R7: An instruction that reads the destination of the load directly ahead of it is held in decode for exactly one cycle. A bubble goes into execute during that cycle, and the loaded value is then forwarded.
- R8: Branches are evaluated in decode, with not-taken assumed. A taken branch redirects fetch to PC+4 plus the sign-extended immediate shifted left by 2, and the single instruction fetched behind it is discarded.
- R9: A branch whose rs or rt matches a register written by an instruction still in execute or memory is held in decode until that producer reaches write-back.
- R10: A register written in write-back is visible to decode reads in the same cycle.
- R11: The load port writes, on a clock edge with `ld_we` high, to the instruction memory (target code 0), the data memory (1) or the register file (2), at word index `ld_addr`. The peek port returns the same storage, selected by the same codes, combinationally.
- R12: Loads and stores address the data memory by word, at byte address (rs + offset) shifted right by 2. A store is visible to a load that directly follows it.
- R13: Control words {dest-is-rd, ALU op[1:0], immediate source, branch, mem read, mem write, reg write, write-back from memory} are: register-register 1,10,0,0,0,0,1,0; load 0,00,1,0,1,0,1,1; store 0,00,1,0,0,1,0,0; branch 0,01,0,1,0,0,0,0; no-operation all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ld_we | input | 1 | Load-port write strobe |
| ld_tgt | input | 2 | Load target: 0 instruction mem, 1 data mem, 2 registers |
| ld_addr | input | ACC_AW | Word index for a load-port write |
| ld_wdata | input | 32 | Load-port write data |
| peek_tgt | input | 2 | Peek target, same codes as `ld_tgt` |
| peek_addr | input | ACC_AW | Word index for a peek |
| peek_data | output | 32 | Combinational peek result |
| pc_o | output | 32 | Current fetch address |

## Verification
The program counter changes one edge after each fetch. Fetch starts two edges after reset release, because of the synchronizer. A register result lands four edges after its instruction leaves fetch, plus one edge for each bubble. A store lands three edges after fetch. The peek port is combinational, so memory and register values can be read back as soon as the relevant edge has passed. The bench therefore preloads everything during reset, lets the program and its stalls drain for a fixed margin well past the last write, and then reads each expected location 1 ns after a falling edge. The reset checks are taken at the falling edge after the asynchronous assertion, and during the synchronizer window after release.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int XLEN = 32;
  localparam int RAW  = 5;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_ANDI  = 6'b001100;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_BNE   = 6'b000101;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  localparam logic [1:0] TGT_IMEM = 2'd0;
  localparam logic [1:0] TGT_DMEM = 2'd1;
  localparam logic [1:0] TGT_REG  = 2'd2;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000, ALU_OR = 3'b001, ALU_ADD = 3'b010,
    ALU_SUB = 3'b110, ALU_SLT = 3'b111
  } alu_fn_e;

  typedef enum logic [1:0] {
    AOP_ADD = 2'b00, AOP_CMP = 2'b01, AOP_FUNCT = 2'b10, AOP_AND = 2'b11
  } alu_op_e;

  typedef enum logic [1:0] {FWD_NONE = 2'd0, FWD_EXM = 2'd1, FWD_WB = 2'd2} fwd_e;

  typedef struct packed {
    logic    dst_rd;
    alu_op_e alu_op;
    logic    src_imm;
    logic    branch;
    logic    mem_rd;
    logic    mem_wr;
    logic    reg_wr;
    logic    wb_mem;
  } ctrl_t;

  typedef struct packed {
    ctrl_t           c;
    alu_fn_e         fn;
    logic [XLEN-1:0] va;
    logic [XLEN-1:0] vb;
    logic [XLEN-1:0] imm;
    logic [RAW-1:0]  rs;
    logic [RAW-1:0]  rt;
    logic [RAW-1:0]  dst;
  } idex_t;

  typedef struct packed {
    logic            reg_wr;
    logic            mem_rd;
    logic            mem_wr;
    logic            wb_mem;
    logic [XLEN-1:0] alu;
    logic [XLEN-1:0] sdata;
    logic [RAW-1:0]  dst;
  } exmem_t;

  typedef struct packed {
    logic            reg_wr;
    logic            wb_mem;
    logic [XLEN-1:0] alu;
    logic [XLEN-1:0] mdata;
    logic [RAW-1:0]  dst;
  } memwb_t;
endpackage

// File: rtl/core_ctrl.sv
module core_ctrl import core_pkg::*; (
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctrl,
  output alu_fn_e         alu_fn,
  output logic            is_bne,
  output logic            zext,
  output logic            use_rs,
  output logic            use_rt
);
  logic [5:0] op;
  logic [5:0] funct;
  logic       funct_ok;

  assign op       = instr[31:26];
  assign funct    = instr[5:0];
  assign funct_ok = (funct == FN_ADD) || (funct == FN_SUB) || (funct == FN_AND) ||
                    (funct == FN_OR)  || (funct == FN_SLT);

  // main decoder: unsupported encodings fall through as all-zero controls
  always_comb begin
    ctrl   = '0;
    is_bne = 1'b0;
    zext   = 1'b0;
    use_rs = 1'b0;
    use_rt = 1'b0;
    case (op)
      OP_RTYPE: if (funct_ok) begin
        ctrl.dst_rd = 1'b1;
        ctrl.alu_op = AOP_FUNCT;
        ctrl.reg_wr = 1'b1;
        use_rs      = 1'b1;
        use_rt      = 1'b1;
      end
      OP_ADDI: begin
        ctrl.alu_op  = AOP_ADD;
        ctrl.src_imm = 1'b1;
        ctrl.reg_wr  = 1'b1;
        use_rs       = 1'b1;
      end
      OP_ANDI: begin
        ctrl.alu_op  = AOP_AND;
        ctrl.src_imm = 1'b1;
        ctrl.reg_wr  = 1'b1;
        zext         = 1'b1;
        use_rs       = 1'b1;
      end
      OP_LW: begin
        ctrl.alu_op  = AOP_ADD;
        ctrl.src_imm = 1'b1;
        ctrl.mem_rd  = 1'b1;
        ctrl.reg_wr  = 1'b1;
        ctrl.wb_mem  = 1'b1;
        use_rs       = 1'b1;
      end
      OP_SW: begin
        ctrl.alu_op  = AOP_ADD;
        ctrl.src_imm = 1'b1;
        ctrl.mem_wr  = 1'b1;
        use_rs       = 1'b1;
        use_rt       = 1'b1;
      end
      OP_BEQ, OP_BNE: begin
        ctrl.alu_op = AOP_CMP;
        ctrl.branch = 1'b1;
        is_bne      = (op == OP_BNE);
        use_rs      = 1'b1;
        use_rt      = 1'b1;
      end
      default: ;
    endcase
  end

  // ALU control from the two-bit class and the function field
  always_comb begin
    case (ctrl.alu_op)
      AOP_ADD: alu_fn = ALU_ADD;
      AOP_CMP: alu_fn = ALU_SUB;
      AOP_AND: alu_fn = ALU_AND;
      default: begin
        case (funct)
          FN_SUB:  alu_fn = ALU_SUB;
          FN_AND:  alu_fn = ALU_AND;
          FN_OR:   alu_fn = ALU_OR;
          FN_SLT:  alu_fn = ALU_SLT;
          default: alu_fn = ALU_ADD;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [W-1:0]            wd,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(NREG)-1:0] ra2,
  input  logic [$clog2(NREG)-1:0] ra3,
  output logic [W-1:0]            rd1,
  output logic [W-1:0]            rd2,
  output logic [W-1:0]            rd3
);
  localparam int AW = $clog2(NREG);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  function automatic logic [W-1:0] rd_port(input logic [AW-1:0] ra);
    if (ra == '0)              return '0;
    else if (we && (wa == ra)) return wd;   // write-before-read
    else                       return regs[ra];
  endfunction

  assign rd1 = rd_port(ra1);
  assign rd2 = rd_port(ra2);
  assign rd3 = rd_port(ra3);
endmodule

// File: rtl/core_hazard.sv
module core_hazard import core_pkg::*; (
  input  logic [RAW-1:0] id_rs,
  input  logic [RAW-1:0] id_rt,
  input  logic           id_use_rs,
  input  logic           id_use_rt,
  input  logic           id_branch,
  input  logic [RAW-1:0] ex_rs,
  input  logic [RAW-1:0] ex_rt,
  input  logic           ex_mem_rd,
  input  logic           ex_reg_wr,
  input  logic [RAW-1:0] ex_dst,
  input  logic           mem_reg_wr,
  input  logic [RAW-1:0] mem_dst,
  input  logic           wb_reg_wr,
  input  logic [RAW-1:0] wb_dst,
  output fwd_e           fwd_a,
  output fwd_e           fwd_b,
  output logic           load_use,
  output logic           br_wait,
  output logic           stall
);
  logic ex_live, mem_live, wb_live;
  logic ex_hit_rs, ex_hit_rt, mem_hit_rs, mem_hit_rt;

  assign ex_live  = ex_reg_wr  && (ex_dst  != '0);
  assign mem_live = mem_reg_wr && (mem_dst != '0);
  assign wb_live  = wb_reg_wr  && (wb_dst  != '0);

  function automatic fwd_e pick(input logic [RAW-1:0] src);
    if (mem_live && (mem_dst == src))     return FWD_EXM;
    else if (wb_live && (wb_dst == src))  return FWD_WB;
    else                                  return FWD_NONE;
  endfunction

  assign fwd_a = pick(ex_rs);
  assign fwd_b = pick(ex_rt);

  assign ex_hit_rs  = ex_live  && (ex_dst  == id_rs);
  assign ex_hit_rt  = ex_live  && (ex_dst  == id_rt);
  assign mem_hit_rs = mem_live && (mem_dst == id_rs);
  assign mem_hit_rt = mem_live && (mem_dst == id_rt);

  assign load_use = ex_mem_rd && ((id_use_rs && ex_hit_rs) || (id_use_rt && ex_hit_rt));
  assign br_wait  = id_branch && (ex_hit_rs || ex_hit_rt || mem_hit_rs || mem_hit_rt);
  assign stall    = load_use || br_wait;
endmodule

// File: rtl/core_alu.sv
module core_alu import core_pkg::*; #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y
);
  logic [W-1:0] diff;
  assign diff = a - b;

  always_comb begin
    case (fn)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/core_pipe5.sv
module core_pipe5 import core_pkg::*; #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int ACC_AW     = 8,
  parameter int NREG       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic [1:0]        ld_tgt,
  input  logic [ACC_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]   ld_wdata,
  input  logic [1:0]        peek_tgt,
  input  logic [ACC_AW-1:0] peek_addr,
  output logic [XLEN-1:0]   peek_data,
  output logic [XLEN-1:0]   pc_o
);
  localparam int IMEM_AW = $clog2(IMEM_WORDS);
  localparam int DMEM_AW = $clog2(DMEM_WORDS);
  localparam logic [XLEN-3:0]   IMEM_LIM  = (XLEN-2)'(IMEM_WORDS);
  localparam logic [ACC_AW-1:0] ACC_ILIM  = ACC_AW'(IMEM_WORDS);
  localparam logic [ACC_AW-1:0] ACC_DLIM  = ACC_AW'(DMEM_WORDS);
  localparam logic [ACC_AW-1:0] ACC_RLIM  = ACC_AW'(NREG);

  // ---------------- reset release synchronizer ----------------
  logic [1:0] rst_pipe;
  logic       core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  // ---------------- storage ----------------
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic ld_imem, ld_dmem, ld_reg;
  assign ld_imem = ld_we && (ld_tgt == TGT_IMEM) && (ld_addr < ACC_ILIM);
  assign ld_dmem = ld_we && (ld_tgt == TGT_DMEM) && (ld_addr < ACC_DLIM);
  assign ld_reg  = ld_we && (ld_tgt == TGT_REG)  && (ld_addr < ACC_RLIM);

  always_ff @(posedge clk) begin
    if (ld_imem) imem[ld_addr[IMEM_AW-1:0]] <= ld_wdata;
  end

  // ---------------- pipeline state ----------------
  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] ifid_instr_q, ifid_instr_d;
  logic [XLEN-1:0] ifid_pc4_q, ifid_pc4_d;
  idex_t           idex_q, idex_d;
  exmem_t          exmem_q, exmem_d;
  memwb_t          memwb_q, memwb_d;

  // ---------------- fetch ----------------
  logic [XLEN-1:0] pc4, if_instr;
  assign pc4      = pc_q + XLEN'(4);
  assign if_instr = (pc_q[XLEN-1:2] < IMEM_LIM) ? imem[pc_q[IMEM_AW+1:2]] : '0;

  // ---------------- decode ----------------
  ctrl_t           id_ctrl;
  alu_fn_e         id_fn;
  logic            id_bne, id_zext, id_use_rs, id_use_rt;
  logic [RAW-1:0]  id_rs, id_rt, id_rd;
  logic [XLEN-1:0] id_imm, id_va, id_vb, br_target;
  logic            br_taken, stall, load_use, br_wait;

  assign id_rs = ifid_instr_q[25:21];
  assign id_rt = ifid_instr_q[20:16];
  assign id_rd = ifid_instr_q[15:11];

  core_ctrl u_ctrl (
    .instr (ifid_instr_q),
    .ctrl  (id_ctrl),
    .alu_fn(id_fn),
    .is_bne(id_bne),
    .zext  (id_zext),
    .use_rs(id_use_rs),
    .use_rt(id_use_rt)
  );

  assign id_imm = id_zext ? {16'h0000, ifid_instr_q[15:0]}
                          : {{16{ifid_instr_q[15]}}, ifid_instr_q[15:0]};

  // write-back and load port share the register file write side
  logic            wb_we, rf_we;
  logic [XLEN-1:0] wb_val, rf_wd, rf_peek;
  logic [RAW-1:0]  rf_wa;
  assign wb_we  = memwb_q.reg_wr;
  assign wb_val = memwb_q.wb_mem ? memwb_q.mdata : memwb_q.alu;
  assign rf_we  = wb_we || ld_reg;
  assign rf_wa  = wb_we ? memwb_q.dst : ld_addr[RAW-1:0];
  assign rf_wd  = wb_we ? wb_val : ld_wdata;

  core_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk(clk), .we(rf_we), .wa(rf_wa), .wd(rf_wd),
    .ra1(id_rs), .ra2(id_rt), .ra3(peek_addr[RAW-1:0]),
    .rd1(id_va), .rd2(id_vb), .rd3(rf_peek)
  );

  fwd_e fwd_a, fwd_b;
  core_hazard u_hz (
    .id_rs(id_rs), .id_rt(id_rt), .id_use_rs(id_use_rs), .id_use_rt(id_use_rt),
    .id_branch(id_ctrl.branch),
    .ex_rs(idex_q.rs), .ex_rt(idex_q.rt), .ex_mem_rd(idex_q.c.mem_rd),
    .ex_reg_wr(idex_q.c.reg_wr), .ex_dst(idex_q.dst),
    .mem_reg_wr(exmem_q.reg_wr), .mem_dst(exmem_q.dst),
    .wb_reg_wr(memwb_q.reg_wr), .wb_dst(memwb_q.dst),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .load_use(load_use), .br_wait(br_wait), .stall(stall)
  );

  assign br_target = ifid_pc4_q + {id_imm[XLEN-3:0], 2'b00};
  assign br_taken  = id_ctrl.branch && !stall && ((id_va == id_vb) != id_bne);

  // fetch / decode next state
  always_comb begin
    pc_d         = pc_q;
    ifid_instr_d = ifid_instr_q;
    ifid_pc4_d   = ifid_pc4_q;
    if (!stall) begin
      pc_d         = br_taken ? br_target : pc4;
      ifid_instr_d = br_taken ? '0 : if_instr;
      ifid_pc4_d   = pc4;
    end
  end

  always_comb begin
    idex_d = '0;
    if (!stall) begin
      idex_d.c   = id_ctrl;
      idex_d.fn  = id_fn;
      idex_d.va  = id_va;
      idex_d.vb  = id_vb;
      idex_d.imm = id_imm;
      idex_d.rs  = id_rs;
      idex_d.rt  = id_rt;
      idex_d.dst = id_ctrl.dst_rd ? id_rd : id_rt;
    end
  end

  // ---------------- execute ----------------
  logic [XLEN-1:0] opa, opb, alu_b, alu_y;

  function automatic logic [XLEN-1:0] fwd_mux(input fwd_e s, input logic [XLEN-1:0] regv);
    case (s)
      FWD_EXM: return exmem_q.alu;
      FWD_WB:  return wb_val;
      default: return regv;
    endcase
  endfunction

  assign opa   = fwd_mux(fwd_a, idex_q.va);
  assign opb   = fwd_mux(fwd_b, idex_q.vb);
  assign alu_b = idex_q.c.src_imm ? idex_q.imm : opb;

  core_alu #(.W(XLEN)) u_alu (.a(opa), .b(alu_b), .fn(idex_q.fn), .y(alu_y));

  always_comb begin
    exmem_d.reg_wr = idex_q.c.reg_wr;
    exmem_d.mem_rd = idex_q.c.mem_rd;
    exmem_d.mem_wr = idex_q.c.mem_wr;
    exmem_d.wb_mem = idex_q.c.wb_mem;
    exmem_d.alu    = alu_y;
    exmem_d.sdata  = opb;
    exmem_d.dst    = idex_q.dst;
  end

  // ---------------- memory ----------------
  logic [DMEM_AW-1:0] dm_idx;
  logic [XLEN-1:0]    dm_rdata;
  assign dm_idx   = exmem_q.alu[DMEM_AW+1:2];
  assign dm_rdata = dmem[dm_idx];

  always_ff @(posedge clk) begin
    if (exmem_q.mem_wr && core_rst_n) dmem[dm_idx] <= exmem_q.sdata;
    else if (ld_dmem)                 dmem[ld_addr[DMEM_AW-1:0]] <= ld_wdata;
  end

  always_comb begin
    memwb_d.reg_wr = exmem_q.reg_wr;
    memwb_d.wb_mem = exmem_q.wb_mem;
    memwb_d.alu    = exmem_q.alu;
    memwb_d.mdata  = exmem_q.mem_rd ? dm_rdata : '0;
    memwb_d.dst    = exmem_q.dst;
  end

  // ---------------- pipeline registers ----------------
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q         <= '0;
      ifid_instr_q <= '0;
      ifid_pc4_q   <= '0;
      idex_q       <= '0;
      exmem_q      <= '0;
      memwb_q      <= '0;
    end else begin
      pc_q         <= pc_d;
      ifid_instr_q <= ifid_instr_d;
      ifid_pc4_q   <= ifid_pc4_d;
      idex_q       <= idex_d;
      exmem_q      <= exmem_d;
      memwb_q      <= memwb_d;
    end
  end

  // ---------------- outputs ----------------
  assign pc_o = pc_q;

  always_comb begin
    case (peek_tgt)
      TGT_IMEM: peek_data = (peek_addr < ACC_ILIM) ? imem[peek_addr[IMEM_AW-1:0]] : '0;
      TGT_DMEM: peek_data = (peek_addr < ACC_DLIM) ? dmem[peek_addr[DMEM_AW-1:0]] : '0;
      TGT_REG:  peek_data = (peek_addr < ACC_RLIM) ? rf_peek : '0;
      default:  peek_data = '0;
    endcase
  end

  // ---------------- assertions ----------------
  a_r8_redirect: assert property (@(posedge clk) disable iff (!core_rst_n)
    br_taken |=> (pc_q == $past(br_target)));

  a_r8_flush: assert property (@(posedge clk) disable iff (!core_rst_n)
    br_taken |=> (ifid_instr_q == '0));

  a_r7_bubble: assert property (@(posedge clk) disable iff (!core_rst_n)
    stall |=> (idex_q.c == '0));

  a_r7_hold: assert property (@(posedge clk) disable iff (!core_rst_n)
    stall |=> ($stable(pc_q) && $stable(ifid_instr_q)));

  a_r7_single: assert property (@(posedge clk) disable iff (!core_rst_n)
    (load_use && !br_wait) |=> !load_use);

  a_r6_no_fwd_zero: assert property (@(posedge clk) disable iff (!core_rst_n)
    ((fwd_a == FWD_EXM) || (fwd_b == FWD_EXM)) |-> (exmem_q.dst != '0));

  a_r9_branch_wait: assert property (@(posedge clk) disable iff (!core_rst_n)
    (id_ctrl.branch && exmem_q.reg_wr && (exmem_q.dst != '0) &&
     ((exmem_q.dst == id_rs) || (exmem_q.dst == id_rt))) |-> stall);

  a_r13_excl: assert property (@(posedge clk) disable iff (!core_rst_n)
    $onehot0({id_ctrl.branch, id_ctrl.mem_rd, id_ctrl.mem_wr}));

  a_r13_lw_word: assert property (@(posedge clk) disable iff (!core_rst_n)
    id_ctrl.mem_rd |-> (id_ctrl.reg_wr && id_ctrl.wb_mem && id_ctrl.src_imm && !id_ctrl.dst_rd));
endmodule

// File: tb/tb_core_pipe5.sv
module tb_core_pipe5;
  localparam int IW = 64;
  localparam int DW = 64;
  localparam int AW = 8;

  localparam logic [5:0] K_ADDI = 6'b001000, K_ANDI = 6'b001100, K_LW = 6'b100011;
  localparam logic [5:0] K_SW = 6'b101011, K_BEQ = 6'b000100, K_BNE = 6'b000101;
  localparam logic [5:0] F_ADD = 6'b100000, F_SUB = 6'b100010, F_AND = 6'b100100;
  localparam logic [5:0] F_OR = 6'b100101, F_SLT = 6'b101010;

  // expected final state: {target, index, value, requirement number}
  localparam int NEXP = 27;
  localparam logic [49:0] EXPECT [NEXP] = '{
    {2'd2, 8'd10, 32'd10,         8'd5},   // R5 chained forwarding
    {2'd2, 8'd11, 32'd8,          8'd2},   // R2 and
    {2'd2, 8'd12, 32'd10,         8'd5},   // R5 both forward paths
    {2'd2, 8'd13, 32'd1,          8'd10},  // R10 same-cycle write/read
    {2'd2, 8'd14, 32'hFFFFFFFD,   8'd3},   // R3 sign extension
    {2'd2, 8'd15, 32'd1,          8'd4},   // R4 signed compare
    {2'd2, 8'd16, 32'h0000F0F0,   8'd3},   // R3 zero extension
    {2'd2, 8'd17, 32'd4,          8'd13},  // R13 load control word
    {2'd2, 8'd18, 32'd8,          8'd7},   // R7 load-use
    {2'd2, 8'd19, 32'd8,          8'd12},  // R12 store then load
    {2'd2, 8'd20, 32'd0,          8'd8},   // R8 flushed/skipped
    {2'd2, 8'd21, 32'd5,          8'd9},   // R9
    {2'd2, 8'd22, 32'd7,          8'd9},   // R9 not-taken path kept
    {2'd2, 8'd23, 32'd0,          8'd8},   // R8 bne taken skip
    {2'd2, 8'd0,  32'd0,          8'd6},   // R6
    {2'd2, 8'd24, 32'd9,          8'd6},   // R6 no forward from reg 0
    {2'd2, 8'd25, 32'd4,          8'd8},   // R8 beq not taken
    {2'd2, 8'd27, 32'd2,          8'd5},   // R5
    {2'd2, 8'd28, 32'd4,          8'd5},   // R5 younger wins
    {2'd2, 8'd29, 32'd0,          8'd2},   // R2 bad function code
    {2'd2, 8'd30, 32'd9,          8'd12},  // R12
    {2'd2, 8'd31, 32'd0,          8'd2},   // R2 bad opcode
    {2'd2, 8'd1,  32'd9,          8'd2},   // R2 untouched
    {2'd1, 8'd5,  32'd8,          8'd12},  // R12 store word
    {2'd1, 8'd0,  32'd10,         8'd12},  // R12 negative offset
    {2'd1, 8'd6,  32'd9,          8'd7},   // R7 store after load
    {2'd1, 8'd3,  32'd8,          8'd11}   // R11 preload kept
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            ld_we;
  logic [1:0]      ld_tgt;
  logic [AW-1:0]   ld_addr;
  logic [31:0]     ld_wdata;
  logic [1:0]      peek_tgt;
  logic [AW-1:0]   peek_addr;
  logic [31:0]     peek_data;
  logic [31:0]     pc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] prog [IW];

  always #2 clk = ~clk;

  core_pipe5 #(.IMEM_WORDS(IW), .DMEM_WORDS(DW), .ACC_AW(AW), .NREG(32)) dut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_tgt(ld_tgt), .ld_addr(ld_addr),
    .ld_wdata(ld_wdata), .peek_tgt(peek_tgt), .peek_addr(peek_addr),
    .peek_data(peek_data), .pc_o(pc_o)
  );

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b00000, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [1:0] t, input int a, input logic [31:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_tgt = t; ld_addr = AW'(a); ld_wdata = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic peek(input logic [1:0] t, input int a, output logic [31:0] v);
    @(negedge clk);
    peek_tgt = t; peek_addr = AW'(a);
    #1 v = peek_data;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; ld_we = 1'b0; ld_tgt = '0; ld_addr = '0; ld_wdata = '0;
    peek_tgt = '0; peek_addr = '0;

    for (int i = 0; i < IW; i++) prog[i] = '0;
    prog[0]  = enc_r(F_ADD, 1, 2, 10);
    prog[1]  = enc_r(F_SUB, 10, 3, 10);
    prog[2]  = enc_r(F_AND, 10, 1, 11);
    prog[3]  = enc_r(F_OR, 10, 11, 12);
    prog[4]  = enc_r(F_SLT, 4, 10, 13);
    prog[5]  = enc_i(K_ADDI, 0, 14, -3);
    prog[6]  = enc_r(F_SLT, 14, 4, 15);
    prog[7]  = enc_i(K_ANDI, 14, 16, 32'hF0F0);
    prog[8]  = enc_i(K_LW, 0, 17, 8);
    prog[9]  = enc_r(F_ADD, 17, 17, 18);
    prog[10] = enc_i(K_SW, 0, 18, 20);
    prog[11] = enc_i(K_LW, 0, 19, 20);
    prog[12] = enc_i(K_BEQ, 19, 18, 2);
    prog[13] = enc_i(K_ADDI, 0, 20, 111);
    prog[14] = enc_i(K_ADDI, 0, 20, 222);
    prog[15] = enc_i(K_ADDI, 0, 21, 5);
    prog[16] = enc_i(K_BNE, 21, 8, 1);
    prog[17] = enc_i(K_ADDI, 0, 22, 7);
    prog[18] = enc_i(K_BNE, 22, 9, 1);
    prog[19] = enc_i(K_ADDI, 0, 23, 1);
    prog[20] = enc_i(K_ADDI, 0, 0, 9);
    prog[21] = enc_r(F_ADD, 0, 1, 24);
    prog[22] = enc_i(K_BEQ, 1, 2, 1);
    prog[23] = enc_i(K_ADDI, 0, 25, 4);
    prog[24] = enc_i(K_SW, 25, 10, -4);
    prog[25] = enc_i(K_ADDI, 0, 27, 1);
    prog[26] = enc_i(K_ADDI, 0, 27, 2);
    prog[27] = enc_r(F_ADD, 27, 27, 28);
    prog[28] = enc_r(6'b000000, 1, 2, 29);
    prog[29] = enc_i(K_LW, 0, 30, 4);
    prog[30] = enc_i(K_SW, 0, 30, 24);
    prog[31] = enc_i(6'b000010, 1, 31, 0);

    @(negedge clk);
    check(1, "pc in reset", pc_o, 32'd0);   // R1

    for (int i = 0; i < IW; i++) poke(2'd0, i, prog[i]);
    for (int i = 0; i < DW; i++) poke(2'd1, i, 32'd0);
    poke(2'd1, 0, 32'd5); poke(2'd1, 1, 32'd9); poke(2'd1, 2, 32'd4);
    poke(2'd1, 3, 32'd8); poke(2'd1, 4, 32'd7);
    for (int i = 0; i < 32; i++) poke(2'd2, i, (i >= 1 && i <= 9) ? 32'(10 - i + ((i >= 4) ? 7 - 2 * (i - 4) + (i - 4) * 2 - 7 + (i - 3) - (10 - i) + (i - 3) : 0)) : 32'd0);
    // explicit register preload values override the formula above
    poke(2'd2, 1, 32'd9); poke(2'd2, 2, 32'd8); poke(2'd2, 3, 32'd7);
    poke(2'd2, 4, 32'd1); poke(2'd2, 5, 32'd2); poke(2'd2, 6, 32'd3);
    poke(2'd2, 7, 32'd4); poke(2'd2, 8, 32'd5); poke(2'd2, 9, 32'd6);
    poke(2'd2, 0, 32'h55);

    peek(2'd2, 0, v);  check(6, "reg0 after load attempt", v, 32'd0);       // R6
    peek(2'd0, 7, v);  check(11, "imem peek", v, prog[7]);                   // R11
    peek(2'd1, 2, v);  check(11, "dmem peek", v, 32'd4);                     // R11
    peek(2'd2, 8, v);  check(11, "reg peek", v, 32'd5);                      // R11
    peek(2'd2, 10, v); check(1, "no write before run", v, 32'd0);           // R1

    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, "pc held during release", pc_o, 32'd0);                        // R1

    repeat (150) @(negedge clk);

    for (int k = 0; k < NEXP; k++) begin
      peek(EXPECT[k][49:48], int'(EXPECT[k][47:40]), v);
      check(int'(EXPECT[k][7:0]), $sformatf("final state tgt%0d[%0d]", EXPECT[k][49:48], EXPECT[k][47:40]),
            v, EXPECT[k][39:8]);
    end

    @(negedge clk);
    rst_n = 1'b0;
    #1 check(1, "pc after async reset", pc_o, 32'd0);                       // R1
    peek(2'd1, 5, v); check(12, "dmem kept over reset", v, 32'd8);          // R12

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule